// File: doc/BRIEF.md
# Accumulator Ping-Pong List Writer

This block serves a single accumulation channel of a hardware queue manager. Descriptors popped from the queues it watches arrive on a valid/ready port. Each one is turned into a two-word entry and written through a simple memory write port into whichever half of a two-half list buffer is currently being filled. A descriptor whose address is zero is consumed but never written, because a zero descriptor word is what the host reads as the end of a list.

A half is closed either when it holds its full number of entries or when a pacing timer runs out while the half is partly filled. Closing a half is a list event. The event bumps a per-channel event counter, marks the half as waiting for the host, raises the interrupt line and moves filling to the other half. When both halves are waiting for the host, the writer stalls instead of overwriting them.

A small register window lets the host manage the interrupt:
- a count register, cleared by writing 1;
- a status register, where writing the channel's bit forces the interrupt;
- a shared end-of-interrupt register, which accepts only the code for this channel and releases the oldest waiting half.

Top module: `acc_list_writer`

## Requirements
- R1: Each accepted non-zero descriptor produces two word writes on consecutive cycles. The first starts in the cycle after acceptance. Word 0 carries the queue number in bits 31:16 with bits 15:0 zero. Word 1 carries the descriptor address. The byte addresses are LIST_BASE + half*8*ENTRIES + 8*index for word 0 and that value + 4 for word 1. LIST_BASE is 8-byte aligned.
- R2: A descriptor with address zero is accepted and discarded. Nothing is written, and the entry slot stays free for the next descriptor.
- R3: The write of word 1 of entry ENTRIES-1 is a list event, and it takes effect at that same clock edge. In the next cycle `irq` is high, the count is one higher and the entry index is back at 0.
- R4: Once the current half holds at least one entry and has not filled, a list event fires TICK_CYCLES*PACE_TICKS cycles after the edge that completed its first entry. TICK_CYCLES defaults to 1250, which is one 25 us pacing unit at 50 MHz.
- R5: Filling starts in half 0 after reset and switches to the other half on every list event.
- R6: `irq` stays high while any half waits for the host or a forced interrupt is pending. Writing 2+CHANNEL to offset 0x010 releases the oldest waiting half and clears the forced flag. Any other value written there has no effect.
- R7: While the half to be filled is still waiting for the host, `desc_ready` is low and no memory write occurs.
- R8: The count register at offset 0x300+4*CHANNEL reads the number of list events. Writing 1 clears it. Writing any other value leaves it unchanged.
- R9: The status register at offset 0x200+4*(CHANNEL/32) reads `irq` at bit CHANNEL%32. Writing a 1 to that bit forces `irq` high without changing the count. Other bits and other offsets have no effect.
- R10: After reset, `desc_ready` is high, `irq` is low, the count reads 0 and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | A popped descriptor is offered |
| desc_qnum | input | QNUM_W | Queue number of the offered descriptor |
| desc_addr | input | 32 | Descriptor address; zero means no descriptor |
| desc_ready | output | 1 | Descriptor accepted at this edge when valid |
| mem_we | output | 1 | List word write strobe |
| mem_addr | output | 32 | Byte address of the list word |
| mem_wdata | output | 32 | List word value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq | output | 1 | Channel interrupt |

## Verification
Inputs are driven on falling edges, and every output is sampled on a falling edge. Each check is therefore tied to a known count of rising edges after its stimulus.
- The word-0 write is checked in the half cycle right after the accepting edge, and word 1 one cycle later.
- A full-list event is visible one falling edge after the word-1 write.
- The pacing event is checked twice: the count must be unchanged at the falling edge just before edge TICK_CYCLES*PACE_TICKS after the first entry completes, and changed at the one just after.
- Register writes are checked at the falling edge that follows their strobe, and reads are taken combinationally in the same half cycle.

// File: rtl/acclw_pkg.sv
package acclw_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_WORD0 = 2'd1,
    WS_WORD1 = 2'd2
  } wr_state_e;

  localparam logic [11:0] EOI_OFF = 12'h010;

  function automatic logic [11:0] count_off(input int unsigned ch);
    return 12'(32'h300 + 32'(ch) * 32'd4);
  endfunction

  function automatic logic [11:0] status_off(input int unsigned ch);
    return 12'(32'h200 + (32'(ch) / 32'd32) * 32'd4);
  endfunction

  function automatic logic [31:0] eoi_code(input int unsigned ch);
    return 32'(ch) + 32'd2;
  endfunction

  function automatic logic [31:0] pace_limit(input int unsigned tick, input int unsigned ticks);
    return 32'(tick) * 32'(ticks);
  endfunction

  function automatic logic [31:0] entry_addr(input logic [31:0] base, input int unsigned entries,
                                             input logic half, input logic [31:0] idx,
                                             input logic word);
    return base + ({31'b0, half} * (32'(entries) << 3)) + (idx << 3) + ({31'b0, word} << 2);
  endfunction

endpackage

// File: rtl/acclw_writer.sv
module acclw_writer
  import acclw_pkg::*;
#(
  parameter int unsigned ENTRIES   = 8,
  parameter int unsigned QNUM_W    = 16,
  parameter logic [31:0] LIST_BASE = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  input  logic [QNUM_W-1:0] desc_qnum,
  input  logic [31:0]       desc_addr,
  output logic              desc_ready,
  input  logic              hold,
  input  logic              pace_evt,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              full_evt,
  output logic              list_evt,
  output logic              cur_half,
  output logic              filling,
  output logic              idle
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  wr_state_e         st_q;
  logic [IDX_W-1:0]  idx_q;
  logic              half_q;
  logic [QNUM_W-1:0] qn_q;
  logic [31:0]       da_q;
  logic              take;

  assign idle       = (st_q == WS_IDLE);
  assign desc_ready = idle && !hold && !pace_evt;
  assign take       = desc_valid && desc_ready;
  assign full_evt   = (st_q == WS_WORD1) && (idx_q == IDX_W'(ENTRIES - 1));
  assign list_evt   = full_evt || pace_evt;
  assign cur_half   = half_q;
  assign filling    = (idx_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      idx_q  <= '0;
      half_q <= 1'b0;
      qn_q   <= '0;
      da_q   <= '0;
    end else begin
      unique case (st_q)
        WS_IDLE: if (take && desc_addr != 32'd0) begin
          qn_q <= desc_qnum;
          da_q <= desc_addr;
          st_q <= WS_WORD0;
        end
        WS_WORD0: st_q <= WS_WORD1;
        default:  st_q <= WS_IDLE;
      endcase
      if (list_evt) begin
        idx_q  <= '0;
        half_q <= ~half_q;
      end else if (st_q == WS_WORD1) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    mem_we    = (st_q != WS_IDLE);
    mem_addr  = entry_addr(LIST_BASE, ENTRIES, half_q, 32'(idx_q), st_q == WS_WORD1);
    mem_wdata = (st_q == WS_WORD1) ? da_q : (32'(qn_q) << 16);
  end

endmodule

// File: rtl/acclw_pacer.sv
module acclw_pacer
  import acclw_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 1250,
  parameter int unsigned PACE_TICKS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic idle,
  output logic pace_evt
);
  localparam logic [31:0] LIM = pace_limit(TICK_CYCLES, PACE_TICKS);

  generate
    if (LIM == 32'd0) begin : g_off
      assign pace_evt = 1'b0;
    end else begin : g_on
      logic [31:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n || !running) cnt_q <= '0;
        else if (cnt_q < LIM - 32'd1) cnt_q <= cnt_q + 32'd1;
      end
      assign pace_evt = running && idle && (cnt_q >= LIM - 32'd1);
    end
  endgenerate

endmodule

// File: rtl/acclw_intd.sv
module acclw_intd
  import acclw_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             list_evt,
  input  logic             cur_half,
  input  logic             reg_we,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq,
  output logic             pend_cur,
  output logic             eoi_hit,
  output logic             cnt_clear,
  output logic [CNT_W-1:0] evt_count
);
  localparam logic [11:0] CNT_OFF  = count_off(CHANNEL);
  localparam logic [11:0] STAT_OFF = status_off(CHANNEL);
  localparam int unsigned BITPOS   = CHANNEL % 32;

  logic [1:0]       pend_q, pend_d;
  logic             ack_q, ack_d;
  logic             retrig_q;
  logic [CNT_W-1:0] cnt_q;
  logic             retrig_set;

  assign eoi_hit    = reg_we && reg_addr == EOI_OFF && reg_wdata == eoi_code(CHANNEL);
  assign cnt_clear  = reg_we && reg_addr == CNT_OFF && reg_wdata == 32'd1;
  assign retrig_set = reg_we && reg_addr == STAT_OFF && reg_wdata[BITPOS];

  always_comb begin
    pend_d = pend_q;
    ack_d  = ack_q;
    if (list_evt) pend_d[cur_half] = 1'b1;
    if (eoi_hit && pend_q[ack_q]) begin
      pend_d[ack_q] = 1'b0;
      ack_d         = ~ack_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      ack_q    <= 1'b0;
      retrig_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      pend_q <= pend_d;
      ack_q  <= ack_d;
      if (retrig_set)   retrig_q <= 1'b1;
      else if (eoi_hit) retrig_q <= 1'b0;
      if (cnt_clear)     cnt_q <= '0;
      else if (list_evt) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign irq       = (|pend_q) || retrig_q;
  assign pend_cur  = pend_q[cur_half];
  assign evt_count = cnt_q;

  always_comb begin
    if (reg_addr == CNT_OFF)       reg_rdata = 32'(cnt_q);
    else if (reg_addr == STAT_OFF) reg_rdata = 32'(irq) << BITPOS;
    else                           reg_rdata = 32'd0;
  end

endmodule

// File: rtl/acc_list_writer.sv
module acc_list_writer
  import acclw_pkg::*;
#(
  parameter int unsigned CHANNEL     = 0,
  parameter int unsigned ENTRIES     = 8,
  parameter int unsigned QNUM_W      = 16,
  parameter int unsigned TICK_CYCLES = 1250,
  parameter int unsigned PACE_TICKS  = 4,
  parameter logic [31:0] LIST_BASE   = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  input  logic [QNUM_W-1:0] desc_qnum,
  input  logic [31:0]       desc_addr,
  output logic              desc_ready,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int unsigned CNT_W = 16;

  logic             full_evt, pace_evt, list_evt;
  logic             cur_half, filling, idle;
  logic             pend_cur, eoi_hit, cnt_clear;
  logic [CNT_W-1:0] evt_count;

  acclw_writer #(.ENTRIES(ENTRIES), .QNUM_W(QNUM_W), .LIST_BASE(LIST_BASE)) u_writer (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_qnum(desc_qnum),
    .desc_addr(desc_addr), .desc_ready(desc_ready), .hold(pend_cur), .pace_evt(pace_evt),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .full_evt(full_evt),
    .list_evt(list_evt), .cur_half(cur_half), .filling(filling), .idle(idle)
  );

  acclw_pacer #(.TICK_CYCLES(TICK_CYCLES), .PACE_TICKS(PACE_TICKS)) u_pacer (
    .clk(clk), .rst_n(rst_n), .running(filling), .idle(idle), .pace_evt(pace_evt)
  );

  acclw_intd #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_intd (
    .clk(clk), .rst_n(rst_n), .list_evt(list_evt), .cur_half(cur_half),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .pend_cur(pend_cur), .eoi_hit(eoi_hit), .cnt_clear(cnt_clear),
    .evt_count(evt_count)
  );

endmodule

// File: rtl/acclw_chk.sv
module acclw_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic [31:0]      desc_addr,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic             irq,
  input logic             full_evt,
  input logic             pace_evt,
  input logic             list_evt,
  input logic             cur_half,
  input logic             pend_cur,
  input logic             eoi_hit,
  input logic             cnt_clear,
  input logic [CNT_W-1:0] evt_count
);
  AST_WORD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !mem_addr[2] |=> mem_we && mem_addr == $past(mem_addr) + 32'd4); // R1
  AST_ZERO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready && desc_addr == 32'd0 |=> !mem_we); // R2
  AST_FULL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |=> irq); // R3
  AST_PACE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |-> !pace_evt); // R4
  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    list_evt |=> cur_half != $past(cur_half)); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !eoi_hit |=> irq); // R6
  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cur |-> !desc_ready && !mem_we); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    list_evt && !cnt_clear |=> evt_count == $past(evt_count) + 1'b1); // R8
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> evt_count == '0); // R8
endmodule

bind acc_list_writer acclw_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_addr(desc_addr), .mem_we(mem_we), .mem_addr(mem_addr), .irq(irq),
  .full_evt(full_evt), .pace_evt(pace_evt), .list_evt(list_evt), .cur_half(cur_half),
  .pend_cur(pend_cur), .eoi_hit(eoi_hit), .cnt_clear(cnt_clear), .evt_count(evt_count)
);

// File: tb/acc_list_writer_tb.sv
`timescale 1ns/1ps
module acc_list_writer_tb;
  localparam int unsigned CH   = 37;
  localparam int unsigned ENT  = 4;
  localparam int unsigned TICK = 4;
  localparam int unsigned NTCK = 3;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam logic [11:0] A_EOI  = 12'h010;
  localparam logic [11:0] A_CNT  = 12'h394;  // 0x300 + 4*37
  localparam logic [11:0] A_STAT = 12'h204;  // 0x200 + 4*(37/32)
  localparam int unsigned PACE = TICK * NTCK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 1'b0;
  logic [15:0] desc_qnum = '0;
  logic [31:0] desc_addr = '0;
  logic desc_ready, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, reg_rdata;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;

  int vectors = 0;
  int fails = 0;
  int writes = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n && mem_we) writes <= writes + 1;

  acc_list_writer #(.CHANNEL(CH), .ENTRIES(ENT), .QNUM_W(16), .TICK_CYCLES(TICK),
                    .PACE_TICKS(NTCK), .LIST_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_qnum(desc_qnum),
    .desc_addr(desc_addr), .desc_ready(desc_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic read_reg(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic write_reg(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Offers one descriptor and checks both word writes (R1); returns one cycle after word 0.
  task automatic push_entry(input logic [15:0] q, input logic [31:0] a, input logic h,
                            input int i, input string tag);
    logic [31:0] w0;
    w0 = BASE + (h ? 32'(8 * ENT) : 32'd0) + 32'(8 * i);
    desc_valid = 1'b1; desc_qnum = q; desc_addr = a;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
    chk("R1", {tag, " word0 we"}, 32'(mem_we), 32'd1);
    chk("R1", {tag, " word0 addr"}, mem_addr, w0);
    chk("R1", {tag, " word0 data"}, mem_wdata, {q, 16'h0000});
    @(negedge clk);
    chk("R1", {tag, " word1 addr"}, mem_addr, w0 + 32'd4);
    chk("R1", {tag, " word1 data"}, mem_wdata, a);
  endtask

  // Waits out the pacing window from the completion of a first entry (R4).
  task automatic pace_window(input logic [31:0] cnt_before, input string tag);
    logic [31:0] d;
    repeat (PACE) @(negedge clk);
    read_reg(A_CNT, d);
    chk("R4", {tag, " count before pacing edge"}, d, cnt_before);
    @(negedge clk);
    read_reg(A_CNT, d);
    chk("R4", {tag, " count after pacing edge"}, d, cnt_before + 32'd1);
    chk("R4", {tag, " irq after pacing"}, 32'(irq), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10", "ready after reset", 32'(desc_ready), 32'd1);
    chk("R10", "irq after reset", 32'(irq), 32'd0);
    chk("R10", "mem_we after reset", 32'(mem_we), 32'd0);
    read_reg(A_CNT, d);
    chk("R10", "count after reset", d, 32'd0);
  endtask

  task automatic t_fill_half0();
    logic [31:0] d;
    for (int i = 0; i < ENT; i++)
      push_entry(16'h0a00 + 16'(i), 32'h0000_1000 + 32'(i * 16), 1'b0, i, "R5 fill half0");
    read_reg(A_CNT, d);
    chk("R3", "count before full edge", d, 32'd0);
    chk("R3", "irq before full edge", 32'(irq), 32'd0);
    @(negedge clk);
    read_reg(A_CNT, d);
    chk("R3", "count after full", d, 32'd1);
    chk("R3", "irq after full", 32'(irq), 32'd1);
    chk("R3", "ready with half1 free", 32'(desc_ready), 32'd1);
  endtask

  task automatic t_pace_and_stall();
    int w;
    push_entry(16'h0b01, 32'h0000_2000, 1'b1, 0, "R5 half1 entry0");
    pace_window(32'd1, "half1");
    chk("R7", "ready with both halves waiting", 32'(desc_ready), 32'd0);
    w = writes;
    desc_valid = 1'b1; desc_qnum = 16'h0bad; desc_addr = 32'h5555_0000;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7", "stalled ready", 32'(desc_ready), 32'd0);
      chk("R7", "stalled write strobe", 32'(mem_we), 32'd0);
    end
    desc_valid = 1'b0;
    chk("R7", "writes during stall", 32'(writes - w), 32'd0);
  endtask

  task automatic t_eoi();
    logic [31:0] d;
    write_reg(A_EOI, 32'd38);
    chk("R6", "irq after wrong eoi code", 32'(irq), 32'd1);
    chk("R6", "still stalled after wrong eoi", 32'(desc_ready), 32'd0);
    write_reg(A_EOI, 32'd39);
    chk("R6", "irq held, half1 still waiting", 32'(irq), 32'd1);
    chk("R6", "half0 released, ready", 32'(desc_ready), 32'd1);
    write_reg(A_EOI, 32'd39);
    chk("R6", "irq low after second eoi", 32'(irq), 32'd0);
    read_reg(A_STAT, d);
    chk("R9", "status bit reads irq low", d, 32'd0);
    push_entry(16'h0c02, 32'h0000_3000, 1'b0, 0, "R5 back to half0");
    pace_window(32'd2, "half0 second");
  endtask

  task automatic t_zero_desc();
    int w;
    w = writes;
    desc_valid = 1'b1; desc_qnum = 16'h0d00; desc_addr = 32'd0;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
    chk("R2", "no write for zero descriptor", 32'(mem_we), 32'd0);
    chk("R2", "ready right after zero descriptor", 32'(desc_ready), 32'd1);
    @(negedge clk);
    chk("R2", "write count unchanged", 32'(writes - w), 32'd0);
    push_entry(16'h0d03, 32'h0000_4000, 1'b1, 0, "R2 slot kept at index0");
    pace_window(32'd3, "half1 second");
  endtask

  task automatic t_count_reg();
    logic [31:0] d;
    write_reg(A_CNT, 32'd5);
    read_reg(A_CNT, d);
    chk("R8", "count after non-one write", d, 32'd4);
    write_reg(A_CNT, 32'd1);
    read_reg(A_CNT, d);
    chk("R8", "count after clear", d, 32'd0);
  endtask

  task automatic t_retrigger();
    logic [31:0] d;
    write_reg(A_EOI, 32'd39);
    write_reg(A_EOI, 32'd39);
    chk("R6", "irq low after releasing both", 32'(irq), 32'd0);
    write_reg(12'h200, 32'h0000_0020);
    chk("R9", "irq after write to other status word", 32'(irq), 32'd0);
    write_reg(A_STAT, 32'h0000_0010);
    chk("R9", "irq after other channel bit", 32'(irq), 32'd0);
    write_reg(A_STAT, 32'h0000_0020);
    chk("R9", "irq after forced bit", 32'(irq), 32'd1);
    read_reg(A_STAT, d);
    chk("R9", "status read shows bit 5", d, 32'h0000_0020);
    read_reg(A_CNT, d);
    chk("R9", "count unchanged by force", d, 32'd0);
    write_reg(A_EOI, 32'd7);
    chk("R6", "forced irq kept on wrong code", 32'(irq), 32'd1);
    write_reg(A_EOI, 32'd39);
    chk("R6", "forced irq cleared by eoi", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_half0();
    t_pace_and_stall();
    t_eoi();
    t_zero_desc();
    t_count_reg();
    t_retrigger();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule